// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Register Bank

This block holds wall-clock time and date as packed BCD bytes in eight byte registers: seven time/calendar registers plus one control byte. A one-cycle pulse from an upstream prescaler marks each elapsed second. That pulse advances seconds, minutes, hours, day of week, day of month, month and year. Month lengths, leap years and a two-state century flag are handled in the same update. A serial-bus front end reads and writes the registers through a byte-wide port. Writes load the masked value directly.

While the bus front end is streaming clock bytes out, it raises a hold input. A second pulse that arrives during the hold is parked in a pending state and not dropped. It is applied when the hold falls, or when a time-out equal to 250 ms of system clock expires, whichever happens first. The control byte is exported whole so that a calibration block can consume it.

Two states form the hold controller. `HOLD_IDLE` is the normal state. `HOLD_PEND` means one accepted second is waiting.

Transitions:
- `HOLD_IDLE` to `HOLD_PEND`: an accepted pulse arrives while the hold is high.
- `HOLD_IDLE` to `HOLD_IDLE` with an update: an accepted pulse arrives while the hold is low.
- `HOLD_PEND` to `HOLD_IDLE` with an update: the hold is low, or the time-out expires.

While in `HOLD_PEND`, further second pulses are ignored.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Byte addresses hold seconds (0), minutes (1), hours (2, bits 5:0), day of week (3, bits 2:0), date (4), month (5) and year (6), all in BCD. An update ripples in one clock cycle. Each field rolls over as follows: seconds 59 to 00 with a carry into minutes, minutes 59 to 00, hours 23 to 00, and the year carries on 99 to 00. The new value is visible on the read port the cycle after the update.
- R2: Bit 7 of the seconds byte is a halt flag. While it is 1, a second pulse changes nothing. After it is cleared, counting resumes with the next pulse.
- R3: Bit 7 of the hours byte enables the century flag, and bit 6 is the century flag. When the enable is 1, the flag inverts on the year rollover 99 to 00. When the enable is 0, the flag never changes on an update.
- R4: The day of week advances at each hour rollover 23 to 00, counting 1 to 7 and wrapping from 7 to 1.
- R5: Month length rules: April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4, including year 00, and 28 days otherwise. All other months have 31 days. The date restarts at 01 and the month advances past the last day.
- R6: A second pulse that arrives while `rd_hold` is 1 is applied in the first cycle in which `rd_hold` is 0. If the hold lasts longer, it is applied after HOLD_CYCLES cycles of waiting. No second is lost in either case.
- R7: After reset, the control byte (address 7) reads 0x80: output level bit 7 = 1, frequency test bit 6 = 0. The time registers read 00:00:00, day 01, date 01, month 01, year 00, with century bits 0.
- R8: Bits with no function read back as 0. The write masks are: minutes 0x7F, day of week 0x07, date 0x3F, month 0x1F. All other registers keep all 8 bits.
- R9: A bus write that falls in the same cycle as an update is discarded.
- R10: `ctrl_byte` always equals the control register, and a write to address 7 is reflected there the next cycle.
- R11: On 31 December with the time at 23:59:59, an update moves the date to 01 January and increments the year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| rd_hold | input | 1 | High while the bus front end reads clock bytes |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address 0 to 7 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| ctrl_byte | output | 8 | Control register for the calibration/output block |

## Verification
The update is driven from preset register images chosen so that the carry stops at different depths. Some presets stop inside seconds or minutes. Others reach a BCD tens digit, the hour boundary, each month length, a leap year and a non-leap February, and the year rollover with the century enable both set and clear. A mismatch in any single image localises the fault to one stage of the ripple.

Directed sequences drive the halt flag with pulses present, and a hold that is released early against one that runs into the time-out. They also drive a bus write colliding with an update, and writes of all-ones that expose the read masks.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [0:0] {
        HOLD_IDLE = 1'b0,
        HOLD_PEND = 1'b1
    } hold_state_e;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } time_regs_t;

    localparam logic [2:0] A_SEC  = 3'd0;
    localparam logic [2:0] A_MIN  = 3'd1;
    localparam logic [2:0] A_HR   = 3'd2;
    localparam logic [2:0] A_DOW  = 3'd3;
    localparam logic [2:0] A_DATE = 3'd4;
    localparam logic [2:0] A_MON  = 3'd5;
    localparam logic [2:0] A_YR   = 3'd6;
    localparam logic [2:0] A_CTRL = 3'd7;

    localparam logic [7:0] CTRL_RESET = 8'h80;

    function automatic logic [7:0] reg_mask(input logic [2:0] a);
        unique case (a)
            A_MIN:   return 8'h7F;
            A_DOW:   return 8'h07;
            A_DATE:  return 8'h3F;
            A_MON:   return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_tick_hold.sv
module rtc_tick_hold
    import rtc_cal_pkg::*;
#(
    parameter int HOLD_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic stop_i,
    input  logic hold_i,
    output logic apply_o,
    output logic pend_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    hold_state_e   st_q, st_nxt;
    logic [CW-1:0] wait_q;
    logic          expire;

    assign expire = (wait_q == CW'(HOLD_CYCLES - 1));
    assign pend_o = (st_q == HOLD_PEND);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= HOLD_IDLE;
            wait_q <= '0;
        end else begin
            st_q   <= st_nxt;
            wait_q <= (st_q == HOLD_PEND) ? wait_q + 1'b1 : '0;
        end
    end

    always_comb begin
        st_nxt  = st_q;
        apply_o = 1'b0;
        unique case (st_q)
            HOLD_IDLE: begin
                if (tick_i && !stop_i) begin
                    if (hold_i) st_nxt = HOLD_PEND;
                    else        apply_o = 1'b1;
                end
            end
            HOLD_PEND: begin
                if (!hold_i || expire) begin
                    apply_o = 1'b1;
                    st_nxt  = HOLD_IDLE;
                end
            end
            default: st_nxt = HOLD_IDLE;
        endcase
    end

    // R6: the wait never outlasts the time-out window
    assert_pend_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> (wait_q < CW'(HOLD_CYCLES)));

endmodule

// File: rtl/rtc_cal_advance.sv
module rtc_cal_advance
    import rtc_cal_pkg::*;
(
    input  time_regs_t cur_i,
    output time_regs_t nxt_o
);
    logic       c_sec, c_min, c_hr, c_date, c_mon, c_yr;
    logic [6:0] ybin;
    logic       leap;
    logic [7:0] last_day;

    always_comb begin
        ybin = ({3'b0, cur_i.yr[7:4]} * 7'd10) + {3'b0, cur_i.yr[3:0]};
        leap = (ybin[1:0] == 2'b00);
        unique case (cur_i.mon)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase

        c_sec  = (cur_i.sec[6:0] == 7'h59);
        c_min  = c_sec  && (cur_i.min  == 8'h59);
        c_hr   = c_min  && (cur_i.hr[5:0] == 6'h23);
        c_date = c_hr   && (cur_i.date == last_day);
        c_mon  = c_date && (cur_i.mon  == 8'h12);
        c_yr   = c_mon  && (cur_i.yr   == 8'h99);

        nxt_o.sec  = {cur_i.sec[7], c_sec ? 7'h00 : bcd_inc({1'b0, cur_i.sec[6:0]})[6:0]};
        nxt_o.min  = !c_sec ? cur_i.min  : (c_min  ? 8'h00 : bcd_inc(cur_i.min));
        nxt_o.hr   = {cur_i.hr[7],
                      cur_i.hr[6] ^ (cur_i.hr[7] & c_yr),
                      !c_min ? cur_i.hr[5:0] : (c_hr ? 6'h00 : bcd_inc({2'b0, cur_i.hr[5:0]})[5:0])};
        nxt_o.dow  = !c_hr ? cur_i.dow :
                     ((cur_i.dow[2:0] == 3'd7) ? 8'h01 : {5'b0, cur_i.dow[2:0] + 3'd1});
        nxt_o.date = !c_hr   ? cur_i.date : (c_date ? 8'h01 : bcd_inc(cur_i.date));
        nxt_o.mon  = !c_date ? cur_i.mon  : (c_mon  ? 8'h01 : bcd_inc(cur_i.mon));
        nxt_o.yr   = !c_mon  ? cur_i.yr   : (c_yr   ? 8'h00 : bcd_inc(cur_i.yr));
    end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int CLK_HZ  = 1000000,
    parameter int HOLD_MS = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       rd_hold,
    input  logic       bus_wr_en,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] ctrl_byte
);
    localparam int HOLD_CYCLES = (CLK_HZ / 1000) * HOLD_MS;

    time_regs_t t_q, t_nxt;
    logic [7:0] ctrl_q;
    logic       apply, pend;
    logic [7:0] wval;

    rtc_tick_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (sec_tick),
        .stop_i  (t_q.sec[7]),
        .hold_i  (rd_hold),
        .apply_o (apply),
        .pend_o  (pend)
    );

    rtc_cal_advance u_adv (
        .cur_i (t_q),
        .nxt_o (t_nxt)
    );

    assign wval = bus_wdata & reg_mask(bus_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q    <= '{yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                        hr: 8'h00, min: 8'h00, sec: 8'h00};
            ctrl_q <= CTRL_RESET;
        end else if (apply) begin
            t_q <= t_nxt;
        end else if (bus_wr_en) begin
            unique case (bus_addr)
                A_SEC:  t_q.sec  <= wval;
                A_MIN:  t_q.min  <= wval;
                A_HR:   t_q.hr   <= wval;
                A_DOW:  t_q.dow  <= wval;
                A_DATE: t_q.date <= wval;
                A_MON:  t_q.mon  <= wval;
                A_YR:   t_q.yr   <= wval;
                A_CTRL: ctrl_q   <= wval;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_SEC:   bus_rdata = t_q.sec;
            A_MIN:   bus_rdata = t_q.min;
            A_HR:    bus_rdata = t_q.hr;
            A_DOW:   bus_rdata = t_q.dow;
            A_DATE:  bus_rdata = t_q.date;
            A_MON:   bus_rdata = t_q.mon;
            A_YR:    bus_rdata = t_q.yr;
            default: bus_rdata = ctrl_q;
        endcase
    end

    assign ctrl_byte = ctrl_q;

    // R2: halted and nothing pending or written -> seconds frozen
    assert_halt_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.sec[7] && !pend && !bus_wr_en) |=> $stable(t_q.sec));

    // R3: century flag untouched when its enable is clear
    assert_century_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_q.hr[7] && !bus_wr_en) |=> $stable(t_q.hr[6]));

    // R4: day of week stays in 1..7 across updates
    assert_dow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && t_q.dow >= 8'd1 && t_q.dow <= 8'd7) |=> (t_q.dow >= 8'd1 && t_q.dow <= 8'd7));

    // R6: a pending second is released once the hold is low
    assert_pend_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !rd_hold) |=> !pend);

    // R7: control byte leaves reset at its defined value
    assert_ctrl_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_byte == CTRL_RESET));

endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 4000;
    localparam int TB_HOLD    = (TB_CLK_HZ / 1000) * 250;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       rd_hold = 1'b0;
    logic       bus_wr_en = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] ctrl_byte;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_bcd_calendar #(.CLK_HZ(TB_CLK_HZ), .HOLD_MS(250)) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .rd_hold(rd_hold),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ctrl_byte(ctrl_byte)
    );

    // {yr,mon,date,dow,hr,min,sec} before -> after one second
    localparam logic [111:0] VEC [14] = '{
        {56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_00_01},  // R1
        {56'h00_01_01_01_00_00_59, 56'h00_01_01_01_00_01_00},  // R1
        {56'h99_12_31_07_A3_59_59, 56'h00_01_01_01_C0_00_00},  // R3 R4 R11
        {56'h99_12_31_03_63_59_59, 56'h00_01_01_04_40_00_00},  // R3
        {56'h24_02_28_02_23_59_59, 56'h24_02_29_03_00_00_00},  // R5 leap
        {56'h23_02_28_02_23_59_59, 56'h23_03_01_03_00_00_00},  // R5
        {56'h24_02_29_05_23_59_59, 56'h24_03_01_06_00_00_00},  // R5
        {56'h10_04_30_01_23_59_59, 56'h10_05_01_02_00_00_00},  // R5
        {56'h10_01_30_01_23_59_59, 56'h10_01_31_02_00_00_00},  // R5
        {56'h00_02_28_01_23_59_59, 56'h00_02_29_02_00_00_00},  // R5 year 00
        {56'h12_02_28_01_23_59_59, 56'h12_02_29_02_00_00_00},  // R5
        {56'h15_09_30_04_23_59_59, 56'h15_10_01_05_00_00_00},  // R5
        {56'h15_09_15_04_09_59_59, 56'h15_09_15_04_10_00_00},  // R1
        {56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00}   // R11
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_all(output logic [55:0] img);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), b);
            img[i*8 +: 8] = b;
        end
    endtask

    task automatic pulse();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    initial begin
        logic [55:0] img;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        rd_all(img);
        chk("R7 time regs", {8'h0, img}, {8'h0, 56'h00_01_01_01_00_00_00});
        rd(3'd7, b);
        chk("R7 ctrl", {56'h0, b}, {56'h0, 8'h80});

        // table walk
        for (int v = 0; v < 14; v++) begin
            for (int i = 0; i < 7; i++) wr(3'(i), VEC[v][56 + i*8 +: 8]);
            pulse();
            rd_all(img);
            chk($sformatf("R1/R3/R4/R5/R11 vector %0d", v), {8'h0, img}, {8'h0, VEC[v][55:0]});
        end

        // R8 masks
        wr(3'd1, 8'hFF); rd(3'd1, b); chk("R8 minutes", {56'h0, b}, {56'h0, 8'h7F});
        wr(3'd3, 8'hFF); rd(3'd3, b); chk("R8 dow",     {56'h0, b}, {56'h0, 8'h07});
        wr(3'd4, 8'hFF); rd(3'd4, b); chk("R8 date",    {56'h0, b}, {56'h0, 8'h3F});
        wr(3'd5, 8'hFF); rd(3'd5, b); chk("R8 month",   {56'h0, b}, {56'h0, 8'h1F});

        // R10 control byte
        wr(3'd7, 8'h45);
        chk("R10 ctrl port", {56'h0, ctrl_byte}, {56'h0, 8'h45});

        // R2 halt flag
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h90);
        pulse(); pulse();
        rd(3'd0, b); chk("R2 halted", {56'h0, b}, {56'h0, 8'h90});
        wr(3'd0, 8'h10);
        pulse();
        rd(3'd0, b); chk("R2 resumed", {56'h0, b}, {56'h0, 8'h11});

        // R6 hold released early
        wr(3'd0, 8'h20);
        @(negedge clk); rd_hold = 1'b1;
        pulse();
        repeat (5) @(negedge clk);
        rd(3'd0, b); chk("R6 deferred", {56'h0, b}, {56'h0, 8'h20});
        rd_hold = 1'b0;
        @(negedge clk);
        rd(3'd0, b); chk("R6 applied on release", {56'h0, b}, {56'h0, 8'h21});

        // R6 hold time-out
        @(negedge clk); rd_hold = 1'b1;
        pulse();
        repeat (TB_HOLD / 2) @(negedge clk);
        rd(3'd0, b); chk("R6 waiting", {56'h0, b}, {56'h0, 8'h21});
        repeat (TB_HOLD) @(negedge clk);
        rd(3'd0, b); chk("R6 time-out", {56'h0, b}, {56'h0, 8'h22});
        rd_hold = 1'b0;
        @(negedge clk);
        rd(3'd0, b); chk("R6 no double", {56'h0, b}, {56'h0, 8'h22});

        // R9 write colliding with update
        wr(3'd0, 8'h05);
        @(negedge clk);
        sec_tick = 1'b1; bus_wr_en = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h33;
        @(negedge clk);
        sec_tick = 1'b0; bus_wr_en = 1'b0;
        rd(3'd0, b); chk("R9 write dropped", {56'h0, b}, {56'h0, 8'h06});

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule